// File: doc/BRIEF.md
# Codec command slot sequencer

This block gives software register access to an external audio codec's control registers through a pair of 20-bit command slot words. Software first writes the data word into the second slot. It then writes a word into the first slot that carries the transfer direction and the codec register address. Only the first-slot write starts a transaction. The transaction runs on a simple request/acknowledge codec register port.

When a read finishes, the block fills two receive registers. The first-slot receive register holds the issued address word with its direction bit cleared. The second-slot receive register holds the returned 16-bit value, left-aligned in 20 bits. Software polls a flag register that shows which slots are empty, which receive registers hold fresh data, and whether a read is still outstanding.

The software side uses a flat select: 0 is slot-1 transmit, 1 is slot-2 transmit, 2 is slot-1 receive, 3 is slot-2 receive and 4 is the flag register. Other selects read as zero and ignore writes. The flag register bits are:

- bit 0: slot-1 transmit empty
- bit 1: slot-2 transmit empty
- bit 2: combined transmit path empty
- bit 3: slot-1 receive busy
- bit 4: slot-2 receive busy
- bit 5: slot-1 receive valid
- bit 6: slot-2 receive valid

Top module: `codec_slot_seq`

## Requirements
- R1: After reset the flag register reads 0x07: bits 0, 1 and 2 are set and all other bits are 0. No codec request is raised.
- R2: A write to select 1 stores the 20-bit word (read back at select 1) and clears flag bit 1. It does not raise a codec request.
- R3: A write to select 0 while no access is in flight stores the word and clears flag bits 0 and 2. It raises `cdc_req` on the next cycle with `cdc_we` = NOT bit 19, `cdc_addr` = bits 18:12 of that word, and `cdc_wdata` = bits 19:4 of the slot-2 word.
- R4: `cdc_req` stays high until the cycle in which `cdc_ack` is seen high, and it is low in the following cycle.
- R5: When an access is acknowledged, flag bits 0, 1 and 2 are set again.
- R6: On a read acknowledge, select 2 reads the slot-1 word with bit 19 cleared, and select 3 reads `cdc_rdata` shifted left by 4 with bits 3:0 zero. A write acknowledge leaves both receive registers unchanged.
- R7: Flag bits 3 and 4 are set from the cycle after a read starts until its acknowledge. After the acknowledge they are clear and flag bits 5 and 6 are set.
- R8: A write to select 0 while an access is in flight is ignored: the slot-1 word is unchanged and no further codec access takes place.
- R9: A read of select 3 clears flag bits 5 and 6 on the next cycle, unless a read completes in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr | input | 1 | Software write strobe |
| sw_rd | input | 1 | Software read strobe (has side effects at select 3) |
| sw_sel | input | 3 | Register select |
| sw_wdata | input | 20 | Software write data |
| sw_rdata | output | 20 | Selected register value (combinational) |
| cdc_req | output | 1 | Codec access request, held until acknowledged |
| cdc_we | output | 1 | 1 for a codec register write, 0 for a read |
| cdc_addr | output | 7 | Codec register address |
| cdc_wdata | output | 16 | Codec write data |
| cdc_ack | input | 1 | Codec access acknowledge |
| cdc_rdata | input | 16 | Codec read data, valid with `cdc_ack` |

## Verification
Wrong internal state shows up at the ports in three ways. A corrupted slot word or field slice appears as a wrong codec address or data value. Such an error is found one full access later, when the bench model's register array is read back through the receive registers and the value does not match. A stuck request or a lost in-flight marker shows within the next few cycles, either as a request that never drops or as a second access that should not happen, and the codec model counts accesses. Flag errors are visible at once in the flag register, which the bench samples before and after every event.

// File: rtl/codec_slot_pkg.sv
package codec_slot_pkg;
    // Slot and codec field geometry
    parameter int SLOT_W = 20;
    parameter int CADDR_W = 7;
    parameter int CDATA_W = 16;
    localparam int DIR_BIT = SLOT_W - 1;
    localparam int ADDR_LSB = DIR_BIT - CADDR_W;
    localparam int DATA_LSB = SLOT_W - CDATA_W;
    localparam int SEL_W = 3;
    localparam int FLAG_W = 7;

    // Software register selects
    localparam logic [SEL_W-1:0] SEL_S1TX = 3'd0;
    localparam logic [SEL_W-1:0] SEL_S2TX = 3'd1;
    localparam logic [SEL_W-1:0] SEL_S1RX = 3'd2;
    localparam logic [SEL_W-1:0] SEL_S2RX = 3'd3;
    localparam logic [SEL_W-1:0] SEL_FLAG = 3'd4;

    // Flag bit positions
    localparam int F_S1E = 0;
    localparam int F_S2E = 1;
    localparam int F_S12E = 2;
    localparam int F_B1 = 3;
    localparam int F_B2 = 4;
    localparam int F_V1 = 5;
    localparam int F_V2 = 6;

    // Events passed from the sequencer to the flag unit
    typedef struct packed {
        logic start;
        logic start_rd;
        logic done;
        logic done_rd;
    } seq_evt_t;
endpackage

// File: rtl/cs_tx_slots.sv
// Transmit slot storage.
// Holds the two software-written slot words. A slot-1 write is
// accepted only when the sequencer reports idle; a slot-2 write is
// always accepted. Assumes one write strobe per cycle.
module cs_tx_slots
    import codec_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_s1,
    input  logic              wr_s2,
    input  logic              idle,
    input  logic [SLOT_W-1:0] wdata,
    output logic [SLOT_W-1:0] s1_q,
    output logic [SLOT_W-1:0] s2_q,
    output logic              s1_accept
);
    assign s1_accept = wr_s1 && idle;

    // Capture slot words on accepted writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            if (s1_accept) s1_q <= wdata;
            if (wr_s2)     s2_q <= wdata;
        end
    end
endmodule

// File: rtl/cs_sequencer.sv
// Codec access sequencer.
// Starts one access per accepted slot-1 write, drives the codec
// request until acknowledge, and fills the receive registers on read
// completion. Assumes the codec returns read data with the acknowledge.
module cs_sequencer
    import codec_slot_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SLOT_W-1:0]  s1_word,
    input  logic [SLOT_W-1:0]  s2_word,
    input  logic [SLOT_W-1:0]  s1_new,
    input  logic               cdc_ack,
    input  logic [CDATA_W-1:0] cdc_rdata,
    output logic               cdc_req,
    output logic               cdc_we,
    output logic [CADDR_W-1:0] cdc_addr,
    output logic [CDATA_W-1:0] cdc_wdata,
    output logic [SLOT_W-1:0]  rx1_q,
    output logic [SLOT_W-1:0]  rx2_q,
    output seq_evt_t           evt
);
    logic done;

    assign done = cdc_req && cdc_ack;

    // Event strobes for the flag unit
    always_comb begin
        evt.start    = start;
        evt.start_rd = start && s1_new[DIR_BIT];
        evt.done     = done;
        evt.done_rd  = done && !cdc_we;
    end

    // Request handshake and field extraction at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cdc_req   <= 1'b0;
            cdc_we    <= 1'b0;
            cdc_addr  <= '0;
            cdc_wdata <= '0;
        end else if (done) begin
            cdc_req <= 1'b0;
        end else if (start) begin
            cdc_req   <= 1'b1;
            cdc_we    <= !s1_new[DIR_BIT];
            cdc_addr  <= s1_new[DIR_BIT-1:ADDR_LSB];
            cdc_wdata <= s2_word[SLOT_W-1:DATA_LSB];
        end
    end

    // Receive registers loaded on read completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx1_q <= '0;
            rx2_q <= '0;
        end else if (done && !cdc_we) begin
            rx1_q <= {1'b0, s1_word[DIR_BIT-1:0]};
            rx2_q <= {cdc_rdata, {DATA_LSB{1'b0}}};
        end
    end
endmodule

// File: rtl/cs_flags.sv
// Slot flag register.
// Tracks the transmit-empty, receive-busy and receive-valid bits from
// sequencer events and software strobes. Setting a valid flag wins over
// a simultaneous software clear; a new slot-2 write wins over a
// completion that sets slot-2 empty.
module cs_flags
    import codec_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_s2,
    input  logic              rd_rx2,
    input  seq_evt_t          evt,
    output logic [FLAG_W-1:0] flags
);
    // Per-bit flag updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= FLAG_W'(7);
        end else begin
            if (evt.start)     flags[F_S1E]  <= 1'b0;
            else if (evt.done) flags[F_S1E]  <= 1'b1;
            if (evt.start)     flags[F_S12E] <= 1'b0;
            else if (evt.done) flags[F_S12E] <= 1'b1;
            if (wr_s2)         flags[F_S2E]  <= 1'b0;
            else if (evt.done) flags[F_S2E]  <= 1'b1;
            if (evt.start_rd) begin
                flags[F_B1] <= 1'b1;
                flags[F_B2] <= 1'b1;
            end else if (evt.done_rd) begin
                flags[F_B1] <= 1'b0;
                flags[F_B2] <= 1'b0;
            end
            if (evt.done_rd) begin
                flags[F_V1] <= 1'b1;
                flags[F_V2] <= 1'b1;
            end else if (rd_rx2) begin
                flags[F_V1] <= 1'b0;
                flags[F_V2] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/codec_slot_seq.sv
// Codec command slot sequencer, top level.
// Decodes software accesses, wires slot storage, access sequencer
// and flag unit, and multiplexes the read-back value. Assumes at most
// one of sw_wr / sw_rd per cycle.
module codec_slot_seq
    import codec_slot_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_wr,
    input  logic               sw_rd,
    input  logic [SEL_W-1:0]   sw_sel,
    input  logic [SLOT_W-1:0]  sw_wdata,
    output logic [SLOT_W-1:0]  sw_rdata,
    output logic               cdc_req,
    output logic               cdc_we,
    output logic [CADDR_W-1:0] cdc_addr,
    output logic [CDATA_W-1:0] cdc_wdata,
    input  logic               cdc_ack,
    input  logic [CDATA_W-1:0] cdc_rdata
);
    logic wr_s1, wr_s2, rd_rx2, s1_accept;
    logic [SLOT_W-1:0] s1_q, s2_q, rx1_q, rx2_q;
    logic [FLAG_W-1:0] flags;
    seq_evt_t evt;

    assign wr_s1  = sw_wr && (sw_sel == SEL_S1TX);
    assign wr_s2  = sw_wr && (sw_sel == SEL_S2TX);
    assign rd_rx2 = sw_rd && (sw_sel == SEL_S2RX);

    cs_tx_slots u_tx (
        .clk(clk), .rst_n(rst_n), .wr_s1(wr_s1), .wr_s2(wr_s2),
        .idle(!cdc_req), .wdata(sw_wdata), .s1_q(s1_q), .s2_q(s2_q),
        .s1_accept(s1_accept)
    );

    cs_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .start(s1_accept), .s1_word(s1_q),
        .s2_word(s2_q), .s1_new(sw_wdata), .cdc_ack(cdc_ack),
        .cdc_rdata(cdc_rdata), .cdc_req(cdc_req), .cdc_we(cdc_we),
        .cdc_addr(cdc_addr), .cdc_wdata(cdc_wdata), .rx1_q(rx1_q),
        .rx2_q(rx2_q), .evt(evt)
    );

    cs_flags u_flags (
        .clk(clk), .rst_n(rst_n), .wr_s2(wr_s2), .rd_rx2(rd_rx2),
        .evt(evt), .flags(flags)
    );

    // Read-back multiplexer
    always_comb begin
        case (sw_sel)
            SEL_S1TX: sw_rdata = s1_q;
            SEL_S2TX: sw_rdata = s2_q;
            SEL_S1RX: sw_rdata = rx1_q;
            SEL_S2RX: sw_rdata = rx2_q;
            SEL_FLAG: sw_rdata = {{(SLOT_W-FLAG_W){1'b0}}, flags};
            default:  sw_rdata = '0;
        endcase
    end
endmodule

// File: rtl/codec_slot_seq_chk.sv
// Protocol checker for codec_slot_seq, bound to every instance.
module codec_slot_seq_chk
    import codec_slot_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sw_wr,
    input logic [SEL_W-1:0]  sw_sel,
    input logic              cdc_req,
    input logic              cdc_we,
    input logic              cdc_ack,
    input logic [SLOT_W-1:0] s1_q,
    input logic [FLAG_W-1:0] flags
);
    logic s1_wr;
    assign s1_wr = sw_wr && (sw_sel == SEL_S1TX);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cdc_req && !cdc_ack |=> cdc_req); // R4
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        cdc_req && cdc_ack |=> !cdc_req); // R4
    AST_START_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        s1_wr && !cdc_req |=> cdc_req && !flags[F_S1E] && !flags[F_S12E]); // R3
    AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        cdc_req && cdc_ack |=> flags[F_S1E] && flags[F_S12E]); // R5
    AST_BUSY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        flags[F_B1] |-> cdc_req && !cdc_we); // R7
    AST_READ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cdc_req && cdc_ack && !cdc_we |=> flags[F_V1] && flags[F_V2] && !flags[F_B2]); // R7
    AST_IGNORE_S1: assert property (@(posedge clk) disable iff (!rst_n)
        cdc_req && s1_wr |=> $stable(s1_q)); // R8
endmodule

bind codec_slot_seq codec_slot_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_sel(sw_sel),
    .cdc_req(cdc_req), .cdc_we(cdc_we), .cdc_ack(cdc_ack),
    .s1_q(s1_q), .flags(flags)
);

// File: tb/codec_slot_seq_test.sv
module codec_slot_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr = 1'b0, sw_rd = 1'b0;
    logic [2:0]  sw_sel = 3'd0;
    logic [19:0] sw_wdata = '0;
    logic [19:0] sw_rdata;
    logic        cdc_req, cdc_we, cdc_ack;
    logic [6:0]  cdc_addr;
    logic [15:0] cdc_wdata, cdc_rdata;

    int checks = 0;
    int fails = 0;
    int accesses = 0;
    int lat_cnt = 0;
    logic [15:0] cmem [128];

    always #5 clk = ~clk;

    codec_slot_seq uut (
        .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_rd(sw_rd),
        .sw_sel(sw_sel), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .cdc_req(cdc_req), .cdc_we(cdc_we), .cdc_addr(cdc_addr),
        .cdc_wdata(cdc_wdata), .cdc_ack(cdc_ack), .cdc_rdata(cdc_rdata)
    );

    // Codec model: acknowledges after three waiting cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            cdc_ack <= 1'b0;
            cdc_rdata <= '0;
            lat_cnt <= 0;
            for (int i = 0; i < 128; i++) cmem[i] <= 16'(i * 16'h0101 + 16'h5a);
        end else begin
            cdc_ack <= 1'b0;
            if (cdc_req && !cdc_ack) begin
                if (lat_cnt == 3) begin
                    cdc_ack <= 1'b1;
                    accesses <= accesses + 1;
                    lat_cnt <= 0;
                    if (cdc_we) cmem[cdc_addr] <= cdc_wdata;
                    else cdc_rdata <= cmem[cdc_addr];
                end else lat_cnt <= lat_cnt + 1;
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sw_write(logic [2:0] sel, logic [19:0] v);
        @(negedge clk);
        sw_wr = 1'b1; sw_sel = sel; sw_wdata = v;
        @(negedge clk);
        sw_wr = 1'b0;
    endtask

    task automatic sw_read(logic [2:0] sel, output logic [19:0] v);
        @(negedge clk);
        sw_rd = 1'b1; sw_sel = sel;
        #1 v = sw_rdata;
        @(negedge clk);
        sw_rd = 1'b0;
    endtask

    task automatic peek(logic [2:0] sel, output logic [19:0] v);
        sw_sel = sel;
        #1 v = sw_rdata;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 50 && cdc_req; k++) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] pat(int a);
        return 16'(a * 16'h3b1 + 16'h1c7);
    endfunction

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [19:0] v;
        logic [19:0] w1;
        int acc0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        peek(3'd4, v); check("R1 flags", v, 20'h07);
        check("R1 req", cdc_req, 0);

        // R2 slot-2 write stores, clears bit1, no request
        sw_write(3'd1, 20'habcd9);
        peek(3'd1, v); check("R2 store", v, 20'habcd9);
        peek(3'd4, v); check("R2 flags", v, 20'h05);
        check("R2 no req", cdc_req, 0);

        // Sweep: write every codec register, checking fields and flags
        for (int a = 0; a < 128; a++) begin
            sw_write(3'd1, {pat(a), 4'(a)});
            w1 = {1'b0, 7'(a), 12'(a * 5)};
            @(negedge clk);
            sw_wr = 1'b1; sw_sel = 3'd0; sw_wdata = w1;
            @(negedge clk);
            sw_wr = 1'b0;
            check("R3 req", cdc_req, 1);
            check("R3 fields", {cdc_we, cdc_addr, cdc_wdata}, {1'b1, 7'(a), pat(a)});
            peek(3'd4, v); check("R3 flags", v & 20'h05, 0);
            wait_idle();
            peek(3'd4, v); check("R5 flags", v, 20'h07);
        end

        // Sweep: read every register back, checking echo and alignment
        for (int a = 0; a < 128; a++) begin
            w1 = {1'b1, 7'(a), 12'(a * 37)};
            sw_write(3'd0, w1);
            peek(3'd4, v); check("R7 busy", v[4:3], 2'b11);
            check("R4 held", cdc_req, 1);
            wait_idle();
            check("R4 dropped", cdc_req, 0);
            peek(3'd4, v); check("R7 done", v, 20'h67);
            peek(3'd2, v); check("R6 rx1 echo", v, {1'b0, w1[18:0]});
            sw_read(3'd3, v); check("R6 rx2 data", v, {pat(a), 4'h0});
            peek(3'd4, v); check("R9 valid cleared", v, 20'h07);
        end

        // R6 a write completion leaves receive registers untouched
        sw_write(3'd1, 20'h12340);
        sw_write(3'd0, {1'b0, 7'd9, 12'h0});
        wait_idle();
        peek(3'd2, v); check("R6 rx1 kept", v, {1'b0, 7'd127, 12'(127 * 37)});
        peek(3'd3, v); check("R6 rx2 kept", v, {pat(127), 4'h0});

        // R8 slot-1 write ignored while in flight
        acc0 = accesses;
        w1 = {1'b1, 7'd9, 12'h3c3};
        sw_write(3'd0, w1);
        sw_write(3'd0, {1'b0, 7'd20, 12'hfff});
        peek(3'd0, v); check("R8 s1 kept", v, w1);
        wait_idle();
        repeat (8) @(negedge clk);
        check("R8 one access", 32'(accesses - acc0), 1);
        peek(3'd2, v); check("R8 echo", v, {1'b0, w1[18:0]});
        peek(3'd3, v); check("R8 data", v, 20'h12340);

        // R9 valid stays set until slot-2 receive is read; other reads do not clear
        sw_read(3'd2, v);
        peek(3'd4, v); check("R9 valid kept", v[6:5], 2'b11);
        sw_read(3'd3, v);
        peek(3'd4, v); check("R9 valid cleared", v[6:5], 2'b00);

        // R1 unused select reads zero and ignores writes
        sw_write(3'd6, 20'hfffff);
        peek(3'd6, v); check("R1 unused", v, 0);
        peek(3'd4, v); check("R1 flags after unused", v, 20'h07);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule